// File: doc/BRIEF.md
# Mirrored Dual-Channel Memory Steering

This block connects a single cache-line request port to two memory channels, A and B. Each line is two chunks: the even chunk sits in the low half of the line and the odd chunk in the high half. When mirroring is on, every line is stored twice. Each channel has a primary DIMM and a mirror DIMM. A write is sent as a primary pass and then a mirror pass. In the mirror pass the chunks change channels, so each channel ends up holding a whole copy of every line.

Reads go to either the primary copy or the mirror copy. The choice comes from one system address bit, and a configuration bit can invert its polarity. The block fetches the chunks as one interleaved access across both channels, or as a pair of reads on one channel. It then returns the line in even/odd order. In fail-down mode only the surviving channel is used. Configuration is sampled when a request is accepted, and only one request is in flight at a time.

Top module: `mirror_steer`

## Requirements
- R1: With mirroring on, a write first issues a primary pass (command mirror flag 0). In that pass channel A receives the even chunk (line bits [CHUNK_W-1:0]) and channel B receives the odd chunk (the high half).
- R2: With mirroring on, a second pass follows with mirror flag 1 and the chunks exchanged: A receives the odd chunk and B the even chunk. It is issued only after both primary commands have been accepted.
- R3: With mirroring off, a write issues only the primary pass. A read is always an interleaved primary read, whatever the address bit, interleave or fail-down settings.
- R4: With mirroring on, a read targets the mirror copy when req_addr[SEL_BIT] XOR cfg_sel_invert is 1, and the primary copy otherwise.
- R5: Interleaved primary read: one read with mirror flag 0 goes to each channel. The A response becomes the even chunk and the B response the odd chunk.
- R6: Interleaved mirror read: one read with mirror flag 1 goes to each channel. The B response becomes the even chunk and the A response the odd chunk.
- R7: Non-interleaved read selecting primary: two reads go to channel A only, flag 0 then flag 1. The first response is the even chunk and the second is the odd chunk.
- R8: Non-interleaved read selecting mirror: two reads go to channel B only, flag 0 then flag 1. The first response is the odd chunk and the second is the even chunk.
- R9: In fail-down mode (mirroring on), only the channel named by cfg_survivor (0 = A, 1 = B) gets commands. A read is the two-read pair of R7/R8 for that channel. A write is two commands, flag 0 then flag 1, carrying chunk (channel XOR flag).
- R10: rsp_valid rises only after both chunks have arrived. rsp_data holds the even chunk in the low half and the odd chunk in the high half.
- R11: req_ready is low from request acceptance until the last write command is accepted, or until the read response is taken. rsp_valid and rsp_data hold steady until rsp_ready.
- R12: During reset, req_ready is high and a_cmd_valid, b_cmd_valid and rsp_valid are low.
- R13: A channel command held without ready keeps its valid, write, mirror, address and data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mirror_en | input | 1 | Mirroring enable |
| cfg_interleave | input | 1 | 1: interleaved reads, 0: single-channel read pair |
| cfg_sel_invert | input | 1 | Inverts the copy-select address bit |
| cfg_faildown | input | 1 | Use one channel only |
| cfg_survivor | input | 1 | Surviving channel in fail-down (0 A, 1 B) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | 2*CHUNK_W | Write line: even low, odd high |
| rsp_valid | output | 1 | Read line valid |
| rsp_ready | input | 1 | Requester takes read line |
| rsp_data | output | 2*CHUNK_W | Reassembled read line |
| a_cmd_valid | output | 1 | Channel A command valid |
| a_cmd_ready | input | 1 | Channel A command ready |
| a_cmd_write | output | 1 | Channel A command is a write |
| a_cmd_mirror | output | 1 | Channel A DIMM select: 0 primary, 1 mirror |
| a_cmd_addr | output | ADDR_W | Channel A address |
| a_cmd_data | output | CHUNK_W | Channel A write chunk |
| a_rsp_valid | input | 1 | Channel A read data valid, in command order |
| a_rsp_data | input | CHUNK_W | Channel A read chunk |
| b_cmd_valid | output | 1 | Channel B command valid |
| b_cmd_ready | input | 1 | Channel B command ready |
| b_cmd_write | output | 1 | Channel B command is a write |
| b_cmd_mirror | output | 1 | Channel B DIMM select: 0 primary, 1 mirror |
| b_cmd_addr | output | ADDR_W | Channel B address |
| b_cmd_data | output | CHUNK_W | Channel B write chunk |
| b_rsp_valid | input | 1 | Channel B read data valid, in command order |
| b_rsp_data | input | CHUNK_W | Channel B read chunk |

## Verification
Each fault shows at the ports in a different way:
- A wrong pass bit shows up on the very next channel command, as a wrong mirror flag or a wrong chunk on a channel.
- A wrong response counter or copy select does not show until the read line comes back, as exchanged halves in rsp_data. So the bench writes distinct halves through the channel models and reads them back in every mode.
- A lost done flag or phase transition stalls the block. req_ready then stays low and the next request never starts.

// File: rtl/mirror_steer.sv
module mirror_steer #(
  parameter int ADDR_W  = 32,
  parameter int CHUNK_W = 32,
  parameter int SEL_BIT = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_mirror_en,
  input  logic                 cfg_interleave,
  input  logic                 cfg_sel_invert,
  input  logic                 cfg_faildown,
  input  logic                 cfg_survivor,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [2*CHUNK_W-1:0] req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [2*CHUNK_W-1:0] rsp_data,
  output logic                 a_cmd_valid,
  input  logic                 a_cmd_ready,
  output logic                 a_cmd_write,
  output logic                 a_cmd_mirror,
  output logic [ADDR_W-1:0]    a_cmd_addr,
  output logic [CHUNK_W-1:0]   a_cmd_data,
  input  logic                 a_rsp_valid,
  input  logic [CHUNK_W-1:0]   a_rsp_data,
  output logic                 b_cmd_valid,
  input  logic                 b_cmd_ready,
  output logic                 b_cmd_write,
  output logic                 b_cmd_mirror,
  output logic [ADDR_W-1:0]    b_cmd_addr,
  output logic [CHUNK_W-1:0]   b_cmd_data,
  input  logic                 b_rsp_valid,
  input  logic [CHUNK_W-1:0]   b_rsp_data
);
  localparam int LINE_W = 2 * CHUNK_W;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_WAIT, S_RSP} st_t;
  st_t st;

  logic [ADDR_W-1:0]  addr_q;
  logic [LINE_W-1:0]  wdata_q;
  logic [CHUNK_W-1:0] even_q, odd_q;
  logic wr_q, mir_q, pair_q, sel_q, ph;
  logic en_a, en_b, done_a, done_b;
  logic rcnt_a, rcnt_b, have_e, have_o;

  logic fd, sm, pr, chn;
  assign fd  = cfg_mirror_en & cfg_faildown;
  assign sm  = cfg_mirror_en & (req_addr[SEL_BIT] ^ cfg_sel_invert);
  assign pr  = cfg_mirror_en & (cfg_faildown | ~cfg_interleave);
  assign chn = cfg_faildown ? cfg_survivor : sm;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RSP);
  assign rsp_data  = {odd_q, even_q};

  assign a_cmd_valid  = (st == S_CMD) & en_a & ~done_a;
  assign a_cmd_write  = wr_q;
  assign a_cmd_mirror = ph;
  assign a_cmd_addr   = addr_q;
  assign a_cmd_data   = ph ? wdata_q[LINE_W-1:CHUNK_W] : wdata_q[CHUNK_W-1:0];

  assign b_cmd_valid  = (st == S_CMD) & en_b & ~done_b;
  assign b_cmd_write  = wr_q;
  assign b_cmd_mirror = ph;
  assign b_cmd_addr   = addr_q;
  assign b_cmd_data   = ph ? wdata_q[CHUNK_W-1:0] : wdata_q[LINE_W-1:CHUNK_W];

  logic dn_a, dn_b, phase_end, more;
  assign dn_a      = done_a | (a_cmd_valid & a_cmd_ready);
  assign dn_b      = done_b | (b_cmd_valid & b_cmd_ready);
  assign phase_end = (~en_a | dn_a) & (~en_b | dn_b);
  assign more      = ~ph & (wr_q ? mir_q : pair_q);

  logic cap_a, cap_b, idx_a, idx_b, got_e, got_o;
  assign cap_a = a_rsp_valid & en_a & ~wr_q & ((st == S_CMD) | (st == S_WAIT));
  assign cap_b = b_rsp_valid & en_b & ~wr_q & ((st == S_CMD) | (st == S_WAIT));
  assign idx_a = pair_q ? rcnt_a : sel_q;
  assign idx_b = ~(pair_q ? rcnt_b : sel_q);
  assign got_e = have_e | (cap_a & ~idx_a) | (cap_b & ~idx_b);
  assign got_o = have_o | (cap_a & idx_a) | (cap_b & idx_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      even_q  <= '0;
      odd_q   <= '0;
      wr_q    <= 1'b0;
      mir_q   <= 1'b0;
      pair_q  <= 1'b0;
      sel_q   <= 1'b0;
      ph      <= 1'b0;
      en_a    <= 1'b0;
      en_b    <= 1'b0;
      done_a  <= 1'b0;
      done_b  <= 1'b0;
      rcnt_a  <= 1'b0;
      rcnt_b  <= 1'b0;
      have_e  <= 1'b0;
      have_o  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_CMD;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          mir_q   <= cfg_mirror_en;
          pair_q  <= pr;
          sel_q   <= sm;
          done_a  <= 1'b0;
          done_b  <= 1'b0;
          rcnt_a  <= 1'b0;
          rcnt_b  <= 1'b0;
          have_e  <= 1'b0;
          have_o  <= 1'b0;
          if (req_write) begin
            ph   <= 1'b0;
            en_a <= ~fd | ~cfg_survivor;
            en_b <= ~fd | cfg_survivor;
          end else begin
            ph   <= pr ? 1'b0 : sm;
            en_a <= ~pr | ~chn;
            en_b <= ~pr | chn;
          end
        end
        S_CMD: begin
          done_a <= dn_a;
          done_b <= dn_b;
          if (phase_end) begin
            if (more) begin
              ph     <= 1'b1;
              done_a <= 1'b0;
              done_b <= 1'b0;
            end else begin
              st <= wr_q ? S_IDLE : S_WAIT;
            end
          end
        end
        S_WAIT: if (got_e & got_o) st <= S_RSP;
        S_RSP:  if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (cap_a) begin
        rcnt_a <= 1'b1;
        if (idx_a) begin odd_q <= a_rsp_data; have_o <= 1'b1; end
        else begin even_q <= a_rsp_data; have_e <= 1'b1; end
      end
      if (cap_b) begin
        rcnt_b <= 1'b1;
        if (idx_b) begin odd_q <= b_rsp_data; have_o <= 1'b1; end
        else begin even_q <= b_rsp_data; have_e <= 1'b1; end
      end
    end
  end
endmodule

// File: rtl/mirror_steer_chk.sv
module mirror_steer_chk #(
  parameter int ADDR_W  = 32,
  parameter int CHUNK_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [2*CHUNK_W-1:0] req_wdata,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [2*CHUNK_W-1:0] rsp_data,
  input logic                 a_cmd_valid,
  input logic                 a_cmd_ready,
  input logic                 a_cmd_write,
  input logic                 a_cmd_mirror,
  input logic [ADDR_W-1:0]    a_cmd_addr,
  input logic [CHUNK_W-1:0]   a_cmd_data,
  input logic                 b_cmd_valid,
  input logic                 b_cmd_ready,
  input logic                 b_cmd_write,
  input logic                 b_cmd_mirror,
  input logic [ADDR_W-1:0]    b_cmd_addr,
  input logic [CHUNK_W-1:0]   b_cmd_data
);
  logic [2*CHUNK_W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow <= '0;
    else if (req_valid && req_ready && req_write) shadow <= req_wdata;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r12_reset_idle: assert (req_ready && !a_cmd_valid && !b_cmd_valid && !rsp_valid)
        else $error("R12 outputs not idle in reset");
    end
  end

  a_r1_a_layout: assert property (@(posedge clk) disable iff (!rst_n)
    a_cmd_valid && a_cmd_write |->
      a_cmd_data == (a_cmd_mirror ? shadow[2*CHUNK_W-1:CHUNK_W] : shadow[CHUNK_W-1:0]));

  a_r2_b_layout: assert property (@(posedge clk) disable iff (!rst_n)
    b_cmd_valid && b_cmd_write |->
      b_cmd_data == (b_cmd_mirror ? shadow[CHUNK_W-1:0] : shadow[2*CHUNK_W-1:CHUNK_W]));

  a_r13_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    a_cmd_valid && !a_cmd_ready |=> a_cmd_valid && $stable(a_cmd_write) &&
      $stable(a_cmd_mirror) && $stable(a_cmd_addr) && $stable(a_cmd_data));

  a_r13_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    b_cmd_valid && !b_cmd_ready |=> b_cmd_valid && $stable(b_cmd_write) &&
      $stable(b_cmd_mirror) && $stable(b_cmd_addr) && $stable(b_cmd_data));

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    a_cmd_valid || b_cmd_valid || rsp_valid |-> !req_ready);

  a_r10_no_cmd_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !a_cmd_valid && !b_cmd_valid);
endmodule

bind mirror_steer mirror_steer_chk #(.ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .a_cmd_valid(a_cmd_valid), .a_cmd_ready(a_cmd_ready), .a_cmd_write(a_cmd_write),
  .a_cmd_mirror(a_cmd_mirror), .a_cmd_addr(a_cmd_addr), .a_cmd_data(a_cmd_data),
  .b_cmd_valid(b_cmd_valid), .b_cmd_ready(b_cmd_ready), .b_cmd_write(b_cmd_write),
  .b_cmd_mirror(b_cmd_mirror), .b_cmd_addr(b_cmd_addr), .b_cmd_data(b_cmd_data));

// File: tb/mirror_steer_bench.sv
module mirror_steer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_mirror_en = 1'b0, cfg_interleave = 1'b1, cfg_sel_invert = 1'b0;
  logic cfg_faildown = 1'b0, cfg_survivor = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0, rsp_data;
  logic rsp_valid, rsp_ready = 1'b0;
  logic a_cmd_valid, a_cmd_ready = 1'b0, a_cmd_write, a_cmd_mirror;
  logic [31:0] a_cmd_addr, a_cmd_data;
  logic a_rsp_valid = 1'b0;
  logic [31:0] a_rsp_data = '0;
  logic b_cmd_valid, b_cmd_ready = 1'b0, b_cmd_write, b_cmd_mirror;
  logic [31:0] b_cmd_addr, b_cmd_data;
  logic b_rsp_valid = 1'b0;
  logic [31:0] b_rsp_data = '0;

  always #5 clk = ~clk;

  mirror_steer u_mirror_steer (.*);

  typedef struct { logic [65:0] v; string tag; } exp_t;
  typedef struct { logic [31:0] d; int t; } pend_t;
  exp_t qa[$], qb[$], qr[$];
  pend_t pa[$], pb[$];
  logic [31:0] mem_a [logic [32:0]];
  logic [31:0] mem_b [logic [32:0]];
  logic [63:0] ref_l [logic [31:0]];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, logic [65:0] act, logic [65:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [65:0] pk(logic w, logic m, logic [31:0] a, logic [31:0] d);
    return {w, m, a, d};
  endfunction

  task automatic cmd_seen(bit ch, logic w, logic m, logic [31:0] a, logic [31:0] d);
    exp_t e;
    logic [65:0] act;
    pend_t p;
    act = pk(w, m, a, w ? d : 32'h0);
    if ((ch ? qb.size() : qa.size()) == 0) begin
      chk(0, "R7/R9 unexpected channel command", act, '0);
      return;
    end
    e = ch ? qb.pop_front() : qa.pop_front();
    chk(act == e.v, e.tag, act, e.v);
    if (w) begin
      if (ch) mem_b[{m, a}] = d; else mem_a[{m, a}] = d;
    end else begin
      p.t = cyc;
      if (ch) begin p.d = mem_b.exists({m, a}) ? mem_b[{m, a}] : 32'hDEAD; pb.push_back(p); end
      else    begin p.d = mem_a.exists({m, a}) ? mem_a[{m, a}] : 32'hDEAD; pa.push_back(p); end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    a_rsp_valid <= 1'b0;
    b_rsp_valid <= 1'b0;
    if (pa.size() > 0 && pa[0].t + 2 <= cyc && ($urandom % 2) == 0) begin
      a_rsp_valid <= 1'b1; a_rsp_data <= pa.pop_front().d;
    end
    if (pb.size() > 0 && pb[0].t + 2 <= cyc && ($urandom % 2) == 0) begin
      b_rsp_valid <= 1'b1; b_rsp_data <= pb.pop_front().d;
    end
    a_cmd_ready = ($urandom % 4) != 0;
    b_cmd_ready = ($urandom % 4) != 0;
    rsp_ready   = ($urandom % 3) != 0;
    if (rst_n && a_cmd_valid && a_cmd_ready) cmd_seen(0, a_cmd_write, a_cmd_mirror, a_cmd_addr, a_cmd_data);
    if (rst_n && b_cmd_valid && b_cmd_ready) cmd_seen(1, b_cmd_write, b_cmd_mirror, b_cmd_addr, b_cmd_data);
    if (rst_n && rsp_valid && rsp_ready) begin
      exp_t e;
      if (qr.size() == 0) chk(0, "R10 unexpected response", {2'b0, rsp_data}, '0);
      else begin
        e = qr.pop_front();
        chk({2'b0, rsp_data} == e.v, e.tag, {2'b0, rsp_data}, e.v);
      end
    end
    if (cyc > 100000 && !finished) begin
      chk(0, "watchdog expired", '0, '0);
      summary();
    end
  end

  task automatic do_req(bit w, logic [31:0] a, logic [63:0] d, string tag);
    exp_t e;
    bit sm, ch;
    e.tag = tag;
    sm = cfg_mirror_en & (a[15] ^ cfg_sel_invert);
    if (w) begin
      ref_l[a] = d;
      if (!cfg_mirror_en) begin
        e.v = pk(1, 0, a, d[31:0]);  qa.push_back(e);
        e.v = pk(1, 0, a, d[63:32]); qb.push_back(e);
      end else if (cfg_faildown) begin
        for (int p = 0; p < 2; p++) begin
          e.v = pk(1, p[0], a, (cfg_survivor ^ p[0]) ? d[63:32] : d[31:0]);
          if (cfg_survivor) qb.push_back(e); else qa.push_back(e);
        end
      end else begin
        e.v = pk(1, 0, a, d[31:0]);  qa.push_back(e);
        e.v = pk(1, 0, a, d[63:32]); qb.push_back(e);
        e.v = pk(1, 1, a, d[63:32]); qa.push_back(e);
        e.v = pk(1, 1, a, d[31:0]);  qb.push_back(e);
      end
    end else begin
      if (!cfg_mirror_en || (cfg_interleave && !cfg_faildown)) begin
        e.v = pk(0, sm, a, 0); qa.push_back(e); qb.push_back(e);
      end else begin
        ch = cfg_faildown ? cfg_survivor : sm;
        for (int p = 0; p < 2; p++) begin
          e.v = pk(0, p[0], a, 0);
          if (ch) qb.push_back(e); else qa.push_back(e);
        end
      end
      e.v = {2'b0, ref_l[a]}; qr.push_back(e);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {"R11 busy after accept ", tag}, {65'b0, req_ready}, '0);
    while (!req_ready) @(negedge clk);
  endtask

  localparam logic [31:0] X0 = 32'h0000_1240, X1 = 32'h0000_9240;
  localparam logic [31:0] X2 = 32'h0001_0080, X3 = 32'h0001_8100, X4 = 32'h0002_8200;

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R12 req_ready in reset", {65'b0, req_ready}, 1);
    chk(!a_cmd_valid && !b_cmd_valid, "R12 cmd valid in reset", {64'b0, a_cmd_valid, b_cmd_valid}, 0);
    chk(rsp_valid == 1'b0, "R12 rsp_valid in reset", {65'b0, rsp_valid}, 0);
    rst_n = 1'b1;
    cfg_mirror_en = 1'b1; cfg_interleave = 1'b1; cfg_sel_invert = 1'b0;
    do_req(1, X0, 64'hAAAA_0001_5555_0000, "R1 R2 mirrored write X0");
    do_req(1, X1, 64'hBBBB_0011_6666_0010, "R1 R2 mirrored write X1");
    do_req(0, X0, 0, "R5 interleaved primary read");
    do_req(0, X1, 0, "R6 interleaved mirror read");
    cfg_sel_invert = 1'b1;
    do_req(0, X0, 0, "R4 inverted select gives mirror");
    do_req(0, X1, 0, "R4 inverted select gives primary");
    cfg_interleave = 1'b0; cfg_sel_invert = 1'b0;
    do_req(0, X0, 0, "R7 pair read on A");
    do_req(0, X1, 0, "R8 pair read on B");
    cfg_sel_invert = 1'b1;
    do_req(0, X0, 0, "R8 R4 pair read on B inverted");
    do_req(0, X1, 0, "R7 R4 pair read on A inverted");
    cfg_sel_invert = 1'b0; cfg_interleave = 1'b1;
    cfg_faildown = 1'b1; cfg_survivor = 1'b0;
    do_req(1, X2, 64'hCCCC_2222_3333_4444, "R9 faildown write A");
    do_req(0, X2, 0, "R9 R10 faildown read A");
    do_req(0, X1, 0, "R9 faildown read A ignores bit");
    cfg_survivor = 1'b1;
    do_req(1, X3, 64'h1357_9BDF_2468_ACE0, "R9 faildown write B");
    do_req(0, X3, 0, "R9 R10 faildown read B");
    do_req(0, X0, 0, "R9 faildown read B old line");
    cfg_faildown = 1'b0;
    cfg_mirror_en = 1'b0; cfg_interleave = 1'b0; cfg_sel_invert = 1'b1;
    do_req(1, X4, 64'h0F0F_1234_F0F0_5678, "R3 unmirrored write");
    do_req(0, X4, 0, "R3 unmirrored read primary");
    cfg_faildown = 1'b1;
    do_req(0, X4, 0, "R3 unmirrored read ignores faildown");
    repeat (10) @(negedge clk);
    chk(qa.size() == 0 && qb.size() == 0, "R7 R9 all channel commands seen", {32'b0, qa.size(), 2'b0} | qb.size(), 0);
    chk(qr.size() == 0, "R10 all responses seen", qr.size(), 0);
    summary();
  end
endmodule